// File: doc/BRIEF.md
# I2C Master START Condition Sequencer

This block forms the START condition of an I2C bus master. Software writes the start-enable bit of a small control register. If both bus lines are seen high at that moment, a reloadable down-counter times two equal hold phases. At the end of the first phase SDA is pulled low while SCL stays released. At the end of the second phase the sequence finishes with SDA still held low, and an interrupt flag is raised.

The lines are open-drain, so the block only ever drives them low. Both line inputs are resynchronised before use. If a line is low when the sequence starts, or SCL drops during the first phase, the block declares a bus collision and returns to idle with both lines released. While a START is running, the block refuses writes to the data buffer, raising a sticky write-collision flag. It also ignores control writes, because it does not queue commands.

Top module: `i2c_start_seq`

## Requirements
- R1: After reset neither line is driven low, and the data buffer, control register and all four status bits (start_seen, irq_flag, bcol_flag, wcol_flag) read zero.
- R2: A control write (wr_sel=1) with bit 0 set, made in idle while both synchronised lines are high, sets ctrl_q[0] and starts the first hold phase. SDA is driven low exactly max(rld_val,1) cycles after that write edge.
- R3: start_seen is set in the same cycle in which SDA first becomes driven low, and it stays set until reset.
- R4: Exactly 2*max(rld_val,1) cycles after the write edge, ctrl_q[0] clears and irq_flag sets, and SDA stays driven low.
- R5: A reload value of zero times each phase as a single clock cycle.
- R6: If either synchronised line is low when the start write is taken, bcol_flag sets, ctrl_q[0] stays 0 and no line is driven.
- R7: SCL seen low during the first phase sets bcol_flag, clears ctrl_q[0] and returns to idle without ever driving SDA.
- R8: A buffer write (wr_sel=0) while ctrl_q[0] is 1 leaves buf_q unchanged and sets wcol_flag. When ctrl_q[0] is 0, a buffer write loads buf_q.
- R9: A control write while ctrl_q[0] is 1 leaves all five bits of ctrl_q unchanged.
- R10: A flag write (wr_sel=2) clears each flag whose data bit is 0 (bit 0 irq_flag, bit 1 bcol_flag, bit 2 wcol_flag) and leaves a flag alone where the bit is 1.
- R11: Outside idle, a control write stores bits 4:1 but cannot set bit 0. scl_drive_low is never asserted.
- R12: Each line input passes two flip-flops. SCL falling before write edge k is acted on at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 buffer, 1 control, 2 flags |
| wr_data | input | 8 | Write data |
| rld_val | input | 7 | Hold-phase reload value in clocks |
| sda_i | input | 1 | SDA line level |
| scl_i | input | 1 | SCL line level |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| buf_q | output | 8 | Transmit data buffer |
| ctrl_q | output | 5 | Control bits, bit 0 start-enable |
| start_seen | output | 1 | START formed on bus |
| irq_flag | output | 1 | Serial port interrupt flag |
| bcol_flag | output | 1 | Bus-collision flag |
| wcol_flag | output | 1 | Write-collision flag |

## Verification
The assertions check on every cycle the ordering rules that hold at any moment. SDA is only ever pulled low together with start_seen and an active start. The interrupt rises only as start-enable falls. A collision never leaves SDA driven. The buffer and control bits do not move under writes made during a START. The exact cycle counts for a given reload value, the zero reload case, the two-flop delay before an SCL drop is acted on, and the selective clearing of flags are shown only by the bench's directed scenarios.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD1 = 2'd1,
        ST_HOLD2 = 2'd2,
        ST_HELD  = 2'd3
    } seq_st_e;

    localparam logic [1:0] SEL_BUF  = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_FLAG = 2'd2;

    localparam int FLG_IRQ  = 0;
    localparam int FLG_BCOL = 1;
    localparam int FLG_WCOL = 2;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[s] <= {WIDTH{RST_VAL}};
            end else if (s == 0) begin
                stg_q[s] <= d_i;
            end else begin
                stg_q[s] <= stg_q[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2cs_brg.sv
module i2cs_brg #(
    parameter int RLD_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [RLD_W-1:0] rld_i,
    output logic             tick_o
);
    localparam logic [RLD_W-1:0] ONE = RLD_W'(1);

    logic [RLD_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (rld_i == '0) ? ONE : rld_i;
        end else if (run_i && cnt_q > ONE) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= ONE;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = run_i && (cnt_q == ONE);
endmodule

// File: rtl/i2c_start_seq.sv
module i2c_start_seq
    import i2cs_pkg::*;
#(
    parameter int RLD_W  = 7,
    parameter int DATA_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [RLD_W-1:0]  rld_val,
    input  logic              sda_i,
    input  logic              scl_i,
    output logic              sda_drive_low,
    output logic              scl_drive_low,
    output logic [DATA_W-1:0] buf_q,
    output logic [4:0]        ctrl_q,
    output logic              start_seen,
    output logic              irq_flag,
    output logic              bcol_flag,
    output logic              wcol_flag
);
    typedef struct packed {
        seq_st_e           st;
        logic              start_en;
        logic [3:0]        ctrl_hi;
        logic [DATA_W-1:0] dbuf;
        logic              seen;
        logic              irq;
        logic              bcol;
        logic              wcol;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [1:0] line_s;
    logic       sda_s, scl_s;
    logic       brg_load, brg_run, brg_tick;
    logic       wr_buf, wr_ctrl, wr_flag;

    i2cs_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_N),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sda_i, scl_i}),
        .q_o   (line_s)
    );

    assign sda_s = line_s[1];
    assign scl_s = line_s[0];

    i2cs_brg #(
        .RLD_W (RLD_W)
    ) u_brg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (brg_load),
        .run_i  (brg_run),
        .rld_i  (rld_val),
        .tick_o (brg_tick)
    );

    assign wr_buf  = wr_en && (wr_sel == SEL_BUF);
    assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
    assign wr_flag = wr_en && (wr_sel == SEL_FLAG);
    assign brg_run = (r_q.st == ST_HOLD1) || (r_q.st == ST_HOLD2);

    always_comb begin
        r_d      = r_q;
        brg_load = 1'b0;

        // software clears flags first so a same-cycle set wins
        if (wr_flag) begin
            r_d.irq  = r_q.irq  & wr_data[FLG_IRQ];
            r_d.bcol = r_q.bcol & wr_data[FLG_BCOL];
            r_d.wcol = r_q.wcol & wr_data[FLG_WCOL];
        end

        // control bits locked while a START runs (no command queue)
        if (wr_ctrl && !r_q.start_en) begin
            r_d.ctrl_hi = wr_data[4:1];
        end

        if (wr_buf) begin
            if (r_q.start_en) r_d.wcol = 1'b1;
            else              r_d.dbuf = wr_data;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (wr_ctrl && wr_data[0]) begin
                    if (sda_s && scl_s) begin
                        r_d.st       = ST_HOLD1;
                        r_d.start_en = 1'b1;
                        brg_load     = 1'b1;
                    end else begin
                        r_d.bcol = 1'b1;
                    end
                end
            end
            ST_HOLD1: begin
                if (!scl_s || (brg_tick && !sda_s)) begin
                    r_d.bcol     = 1'b1;
                    r_d.start_en = 1'b0;
                    r_d.st       = ST_IDLE;
                end else if (brg_tick) begin
                    r_d.st   = ST_HOLD2;
                    r_d.seen = 1'b1;
                    brg_load = 1'b1;
                end
            end
            ST_HOLD2: begin
                if (brg_tick) begin
                    r_d.st       = ST_HELD;
                    r_d.start_en = 1'b0;
                    r_d.irq      = 1'b1;
                end
            end
            default: begin
                r_d.st = ST_HELD;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, start_en: 1'b0, ctrl_hi: '0, dbuf: '0,
                     seen: 1'b0, irq: 1'b0, bcol: 1'b0, wcol: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_drive_low = (r_q.st == ST_HOLD2) || (r_q.st == ST_HELD);
    assign scl_drive_low = 1'b0;
    assign buf_q         = r_q.dbuf;
    assign ctrl_q        = {r_q.ctrl_hi, r_q.start_en};
    assign start_seen    = r_q.seen;
    assign irq_flag      = r_q.irq;
    assign bcol_flag     = r_q.bcol;
    assign wcol_flag     = r_q.wcol;
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic              sda_drive_low,
    input logic [DATA_W-1:0] buf_q,
    input logic [4:0]        ctrl_q,
    input logic              start_seen,
    input logic              irq_flag,
    input logic              bcol_flag
);
    // R3
    sda_low_with_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> (start_seen && ctrl_q[0]));

    // R4
    irq_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> ($past(ctrl_q[0]) && !ctrl_q[0] && sda_drive_low));

    // R7
    bcol_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bcol_flag) |-> (!sda_drive_low && !ctrl_q[0]));

    // R8
    buf_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && ctrl_q[0]) |=> $stable(buf_q));

    // R9
    ctrl_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && ctrl_q[0]) |=> (ctrl_q[4:1] == $past(ctrl_q[4:1])));
endmodule

bind i2c_start_seq i2cs_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .sda_drive_low (sda_drive_low),
    .buf_q         (buf_q),
    .ctrl_q        (ctrl_q),
    .start_seen    (start_seen),
    .irq_flag      (irq_flag),
    .bcol_flag     (bcol_flag)
);

// File: tb/i2c_start_seq_tb.sv
`timescale 1ns/1ps
module i2c_start_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [6:0] rld_val = 7'd4;
    logic       sda_ext = 1'b1;
    logic       scl_ext = 1'b1;
    logic       sda_i, scl_i;
    logic       sda_drive_low, scl_drive_low;
    logic [7:0] buf_q;
    logic [4:0] ctrl_q;
    logic       start_seen, irq_flag, bcol_flag, wcol_flag;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign sda_i = sda_ext & ~sda_drive_low;
    assign scl_i = scl_ext & ~scl_drive_low;

    i2c_start_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rld_val(rld_val), .sda_i(sda_i), .scl_i(scl_i),
        .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
        .buf_q(buf_q), .ctrl_q(ctrl_q), .start_seen(start_seen),
        .irq_flag(irq_flag), .bcol_flag(bcol_flag), .wcol_flag(wcol_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; sda_ext = 1'b1; scl_ext = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // returns at the negedge after the write edge
    task automatic reg_write(input logic [1:0] sel, input logic [7:0] val);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 sda", sda_drive_low, 0);
        check("R1 scl", scl_drive_low, 0);
        check("R1 buf", buf_q, 0);
        check("R1 ctrl", ctrl_q, 0);
        check("R1 flags", {start_seen, irq_flag, bcol_flag, wcol_flag}, 0);
    endtask

    task automatic t_start(input int n);
        int ne;
        ne = (n == 0) ? 1 : n;
        do_reset();
        rld_val = 7'(n);
        reg_write(2'd1, 8'h01);
        for (int m = 0; m <= 2 * ne + 1; m++) begin
            check("R2 sda timing", sda_drive_low, (m >= ne) ? 1 : 0);
            check("R3 seen", start_seen, (m >= ne) ? 1 : 0);
            check("R4 start_en", ctrl_q[0], (m < 2 * ne) ? 1 : 0);
            check((n == 0) ? "R5 irq zero reload" : "R4 irq", irq_flag, (m >= 2 * ne) ? 1 : 0);
            check("R11 scl", scl_drive_low, 0);
            @(negedge clk);
        end
        check("R4 no bcol", bcol_flag, 0);
    endtask

    task automatic t_col_at_start(input logic sda_v, input logic scl_v);
        do_reset();
        rld_val = 7'd3;
        sda_ext = sda_v; scl_ext = scl_v;
        repeat (3) @(negedge clk);
        reg_write(2'd1, 8'h01);
        check("R6 bcol", bcol_flag, 1);
        check("R6 start_en", ctrl_q[0], 0);
        repeat (5) @(negedge clk);
        check("R6 sda", sda_drive_low, 0);
        check("R6 seen", start_seen, 0);
    endtask

    task automatic t_col_mid();
        do_reset();
        rld_val = 7'd10;
        reg_write(2'd1, 8'h01);
        @(negedge clk);            // m=1
        @(negedge clk);            // m=2
        scl_ext = 1'b0;
        @(negedge clk);            // m=3
        @(negedge clk);            // m=4
        check("R12 not yet", bcol_flag, 0);
        check("R12 still running", ctrl_q[0], 1);
        @(negedge clk);            // m=5
        check("R7 bcol", bcol_flag, 1);
        check("R7 start_en", ctrl_q[0], 0);
        repeat (12) @(negedge clk);
        check("R7 sda never", sda_drive_low, 0);
        check("R7 seen", start_seen, 0);
    endtask

    task automatic t_guard();
        do_reset();
        rld_val = 7'd8;
        reg_write(2'd0, 8'h3C);
        check("R8 idle load", buf_q, 8'h3C);
        reg_write(2'd1, 8'h01);
        reg_write(2'd0, 8'hA5);
        check("R8 buf kept", buf_q, 8'h3C);
        check("R8 wcol", wcol_flag, 1);
        reg_write(2'd1, 8'h1E);
        check("R9 ctrl kept", ctrl_q, 5'h01);
        repeat (20) @(negedge clk);
        check("R4 done", irq_flag, 1);
        check("R4 sda held", sda_drive_low, 1);
        reg_write(2'd0, 8'h77);
        check("R8 after load", buf_q, 8'h77);
        reg_write(2'd1, 8'h1F);
        check("R11 start ignored", ctrl_q, 5'h1E);
        repeat (3) @(negedge clk);
        check("R11 sda still held", sda_drive_low, 1);
        reg_write(2'd2, 8'h03);
        check("R10 partial", {wcol_flag, bcol_flag, irq_flag}, 3'b001);
        reg_write(2'd2, 8'h00);
        check("R10 all clear", {wcol_flag, bcol_flag, irq_flag}, 3'b000);
        check("R3 seen stays", start_seen, 1);
    endtask

    task automatic t_bcol_clear();
        t_col_at_start(1'b0, 1'b0);
        reg_write(2'd2, 8'h05);
        check("R10 bcol cleared", bcol_flag, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_start(4);
        t_start(1);
        t_start(0);
        t_start(7);
        t_col_at_start(1'b0, 1'b0);
        t_col_at_start(1'b1, 1'b0);
        t_col_at_start(1'b0, 1'b1);
        t_col_mid();
        t_guard();
        t_bcol_clear();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule